// File: doc/BRIEF.md
# Slave I2S/TDM Slot Transmitter

This block is the output side of a serial audio port that runs as a bus slave. An outside master supplies the bit clock and the frame sync. The block shifts one stereo pair of 24-bit two's-complement PCM words onto a single data line, MSB first. The line also has an output-enable, so the pad can float whenever the port is not sending. Frame sync is sampled on the rising edge of the bit clock. Data and enable change on the falling edge.

Two control codes set the frame layout. `ratio_code` reports the measured bit-clock-to-frame-sync ratio, which fixes how many 32-clock slots a frame holds. `slot_cfg` selects either stereo I2S or one of four TDM slot pairs. Both codes are plain static pins. In I2S the frame starts at the falling edge of frame sync and channel 1 starts at the rising edge. In TDM the frame starts at the rising edge of a sync pulse, and the pulse width does not matter. A slot pair that lies past the end of the frame is never sent.

Samples arrive on a valid/ready stream. One pair can wait in a holding register. At each frame start the held pair moves into the frame register, which drives every slot of that frame, and `in_ready` rises again. A producer must keep `in_valid` and the data steady until a rising bit-clock edge sees `in_ready` high. The port therefore back-pressures the producer to one pair per frame. If no pair is held at a frame start, the previous pair is sent again.

Top module: `sdo_slot_tx`

## Requirements
- R1: The port runs in I2S when `slot_cfg[2]`=1 or when `ratio_code`=0 (64 clocks per frame). A falling sync edge starts the frame, with channel 0 in slot 0. A rising sync edge restarts the bit position at 32, so channel 1 begins in slot 1 from that edge.
- R2: In TDM (`slot_cfg[2]`=0 and `ratio_code`≠0), only a rising sync edge starts a frame. The falling edge and the pulse width have no effect on the output.
- R3: In TDM, `slot_cfg[1:0]`=p places channel 0 in slot 2p and channel 1 in slot 2p+1. Slots are counted from 0, and each slot is 32 bit clocks long.
- R4: The ratio codes 1, 2, 3, 4 and 5–7 give 4, 6, 8, 12 and 16 slots per frame. A target slot whose index is at or past that count is never driven.
- R5: In a driven slot, bit clock 0 carries sample bit 23 and bit clock 23 carries bit 0, with no one-clock delay. Bit clocks 24 to 31 carry 0 with the enable still high.
- R6: Outside the two selected slots, `sdata_oe` is 0 and `sdata` is 0.
- R7: `sdata` and `sdata_oe` change only on falling bit-clock edges. The first bit of a frame appears at the falling edge that follows the rising edge that sampled the frame-start sync edge.
- R8: `in_ready` is high exactly when no pair is held. A pair is taken at a rising edge with `in_valid` and `in_ready` both high. `in_ready` then stays low until the next frame start.
- R9: A frame sends the pair held at its start. If none is held, it repeats the last pair it sent, which is zero after reset.
- R10: Under reset, `sdata_oe`=0, `sdata`=0 and `in_ready`=1. Nothing is driven until the first frame start after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock from the bus master |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync | input | 1 | Frame sync from the bus master |
| in_valid | input | 1 | Sample pair on `in_ch0`/`in_ch1` is valid |
| in_ready | output | 1 | Holding register is empty and can take a pair |
| in_ch0 | input | 24 | Channel 0 sample, two's complement |
| in_ch1 | input | 24 | Channel 1 sample, two's complement |
| ratio_code | input | 3 | Clocks per frame: 0=64, 1=128, 2=192, 3=256, 4=384, 5–7=512 |
| slot_cfg | input | 3 | Bit 2 forces I2S; bits 1:0 select the TDM slot pair |
| sdata | output | 1 | Serial data value |
| sdata_oe | output | 1 | Drive enable for the data pad |

## Verification
The output bit and enable for a given bit position are due half a bit clock after the rising edge that set that position. The bench model therefore evaluates them 1 ns after each falling edge and compares them with the design 1 ns after the next rising edge, while both are stable. `in_ready` and sample capture take effect at the rising edge that sees the handshake or the frame-start sync edge, so the model updates its state at that edge and compares `in_ready` straight after. All stimulus changes 3 ns after a falling edge, well clear of both clock edges.

// File: rtl/sdo_pkg.sv
package sdo_pkg;

  typedef enum logic [2:0] {
    RATIO_64  = 3'd0,
    RATIO_128 = 3'd1,
    RATIO_192 = 3'd2,
    RATIO_256 = 3'd3,
    RATIO_384 = 3'd4,
    RATIO_512 = 3'd5
  } ratio_e;

  // Number of 32-clock slots a frame holds for the given ratio code.
  function automatic int unsigned slot_count(input logic [2:0] code, input logic i2s);
    if (i2s) return 2;
    case (ratio_e'(code))
      RATIO_128: return 4;
      RATIO_192: return 6;
      RATIO_256: return 8;
      RATIO_384: return 12;
      default:   return 16;
    endcase
  endfunction

endpackage

// File: rtl/sdo_frame_tracker.sv
module sdo_frame_tracker #(
  parameter int CNT_W    = 11,
  parameter int SLOT_LEN = 32
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             fsync,
  input  logic             i2s_mode,
  output logic             frame_start,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             locked
);
  logic fs_q;
  logic rise, fall, half_start;

  assign rise        = fsync & ~fs_q;
  assign fall        = ~fsync & fs_q;
  assign frame_start = i2s_mode ? fall : rise;
  assign half_start  = i2s_mode & rise;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q    <= 1'b0;
      bit_cnt <= '1;
      locked  <= 1'b0;
    end else begin
      fs_q <= fsync;
      if (frame_start) begin
        bit_cnt <= '0;
        locked  <= 1'b1;
      end else if (half_start) begin
        bit_cnt <= CNT_W'(SLOT_LEN);
      end else if (bit_cnt != '1) begin
        bit_cnt <= bit_cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sdo_sample_buffer.sv
module sdo_sample_buffer #(
  parameter int W = 24
) (
  input  logic         bclk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_ch0,
  input  logic [W-1:0] in_ch1,
  input  logic         frame_start,
  output logic [W-1:0] cur_ch0,
  output logic [W-1:0] cur_ch1
);
  logic         hold_full;
  logic [W-1:0] hold_ch0, hold_ch1;

  assign in_ready = ~hold_full;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_ch0  <= '0;
      hold_ch1  <= '0;
      cur_ch0   <= '0;
      cur_ch1   <= '0;
    end else if (frame_start && hold_full) begin
      cur_ch0   <= hold_ch0;
      cur_ch1   <= hold_ch1;
      hold_full <= 1'b0;
    end else if (in_valid && !hold_full) begin
      hold_ch0  <= in_ch0;
      hold_ch1  <= in_ch1;
      hold_full <= 1'b1;
    end
  end
endmodule

// File: rtl/sdo_slot_mapper.sv
module sdo_slot_mapper #(
  parameter int W        = 24,
  parameter int SLOT_LEN = 32,
  parameter int CNT_W    = 11,
  localparam int SLOT_LOG = $clog2(SLOT_LEN),
  localparam int SIW      = CNT_W - SLOT_LOG
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             locked,
  input  logic             i2s_mode,
  input  logic [1:0]       pair_sel,
  input  logic [SIW-1:0]   nslots,
  input  logic [W-1:0]     cur_ch0,
  input  logic [W-1:0]     cur_ch1,
  output logic             sdata,
  output logic             sdata_oe
);
  logic [SIW-1:0]      slot_idx, tgt0, tgt1;
  logic [SLOT_LOG-1:0] bit_idx;
  logic                hit0, hit1, drive;
  logic [W-1:0]        sel_word;
  logic [SLOT_LEN-1:0] slot_word;

  assign slot_idx  = bit_cnt[CNT_W-1:SLOT_LOG];
  assign bit_idx   = bit_cnt[SLOT_LOG-1:0];
  assign tgt0      = i2s_mode ? '0 : SIW'({pair_sel, 1'b0});
  assign tgt1      = tgt0 + SIW'(1);
  assign hit0      = slot_idx == tgt0;
  assign hit1      = slot_idx == tgt1;
  assign drive     = locked && (slot_idx < nslots) && (hit0 || hit1);
  assign sel_word  = hit0 ? cur_ch0 : cur_ch1;
  // Pad the sample with zeros to a full slot: the tail bits go out low.
  assign slot_word = {sel_word, {(SLOT_LEN-W){1'b0}}};

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      sdata    <= 1'b0;
      sdata_oe <= 1'b0;
    end else begin
      sdata_oe <= drive;
      sdata    <= drive & slot_word[SLOT_LOG'(SLOT_LEN-1) - bit_idx];
    end
  end
endmodule

// File: rtl/sdo_slot_tx.sv
module sdo_slot_tx #(
  parameter int W        = 24,
  parameter int SLOT_LEN = 32,
  parameter int CNT_W    = 11,
  localparam int SIW     = CNT_W - $clog2(SLOT_LEN)
) (
  input  logic         bclk,
  input  logic         rst_n,
  input  logic         fsync,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_ch0,
  input  logic [W-1:0] in_ch1,
  input  logic [2:0]   ratio_code,
  input  logic [2:0]   slot_cfg,
  output logic         sdata,
  output logic         sdata_oe
);
  logic             i2s_mode, frame_start, locked;
  logic [CNT_W-1:0] bit_cnt;
  logic [SIW-1:0]   nslots;
  logic [W-1:0]     cur_ch0, cur_ch1;

  assign i2s_mode = slot_cfg[2] | (ratio_code == 3'd0);
  assign nslots   = SIW'(sdo_pkg::slot_count(ratio_code, i2s_mode));

  sdo_frame_tracker #(.CNT_W(CNT_W), .SLOT_LEN(SLOT_LEN)) u_track (
    .bclk(bclk), .rst_n(rst_n), .fsync(fsync), .i2s_mode(i2s_mode),
    .frame_start(frame_start), .bit_cnt(bit_cnt), .locked(locked)
  );

  sdo_sample_buffer #(.W(W)) u_buf (
    .bclk(bclk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ch0(in_ch0), .in_ch1(in_ch1), .frame_start(frame_start),
    .cur_ch0(cur_ch0), .cur_ch1(cur_ch1)
  );

  sdo_slot_mapper #(.W(W), .SLOT_LEN(SLOT_LEN), .CNT_W(CNT_W)) u_map (
    .bclk(bclk), .rst_n(rst_n), .bit_cnt(bit_cnt), .locked(locked),
    .i2s_mode(i2s_mode), .pair_sel(slot_cfg[1:0]), .nslots(nslots),
    .cur_ch0(cur_ch0), .cur_ch1(cur_ch1), .sdata(sdata), .sdata_oe(sdata_oe)
  );
endmodule

// File: rtl/sdo_slot_tx_chk.sv
module sdo_slot_tx_chk (
  input logic       bclk,
  input logic       rst_n,
  input logic       fsync,
  input logic       in_valid,
  input logic       in_ready,
  input logic [2:0] ratio_code,
  input logic [2:0] slot_cfg,
  input logic       sdata,
  input logic       sdata_oe
);
  logic fs_prev, seen_edge;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      fs_prev   <= 1'b0;
      seen_edge <= 1'b0;
    end else begin
      fs_prev <= fsync;
      if (fsync != fs_prev) seen_edge <= 1'b1;
    end
  end

  // R6
  released_low_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    !sdata_oe |-> !sdata);

  // R8
  ready_drop_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R4
  beyond_frame_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    (ratio_code == 3'd1 && !slot_cfg[2] && slot_cfg[1] &&
     $stable(ratio_code) && $stable(slot_cfg)) |-> !sdata_oe);

  // R10
  idle_no_drive_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    !seen_edge |-> !sdata_oe);
endmodule

bind sdo_slot_tx sdo_slot_tx_chk chk_i (.*);

// File: tb/tb_sdo_slot_tx.sv
module tb_sdo_slot_tx;
  logic        bclk = 1'b0;
  logic        rst_n, fsync, in_valid, in_ready, sdata, sdata_oe;
  logic [23:0] in_ch0, in_ch1;
  logic [2:0]  ratio_code, slot_cfg;

  always #5 bclk = ~bclk;

  sdo_slot_tx dut (.*);

  int n_cmp = 0, n_bad = 0, k = 0;
  string tag = "R10";
  bit model_on = 0, feed_on = 0;
  // reference model state
  int m_cnt = 2047;
  bit m_locked = 0, m_fsq = 0, m_hfull = 0, m_acc = 0, exp_oe = 0, exp_sd = 0;
  logic [23:0] m_h0 = 0, m_h1 = 0, m_f0 = 0, m_f1 = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  function automatic bit is_i2s();
    return slot_cfg[2] || ratio_code == 3'd0;
  endfunction

  function automatic int slots();
    if (is_i2s()) return 2;
    case (ratio_code)
      3'd1: return 4;
      3'd2: return 6;
      3'd3: return 8;
      3'd4: return 12;
      default: return 16;
    endcase
  endfunction

  task automatic model_pos();
    bit st, mid;
    st  = is_i2s() ? (m_fsq && !fsync) : (!m_fsq && fsync);
    mid = is_i2s() && !m_fsq && fsync;
    m_acc = 0;
    if (st) begin m_cnt = 0; m_locked = 1; end
    else if (mid) m_cnt = 32;
    else if (m_cnt < 2047) m_cnt++;
    if (st && m_hfull) begin m_f0 = m_h0; m_f1 = m_h1; m_hfull = 0; end
    else if (in_valid && !m_hfull) begin m_h0 = in_ch0; m_h1 = in_ch1; m_hfull = 1; m_acc = 1; end
    m_fsq = fsync;
  endtask

  task automatic model_neg();
    int slot, b, t0;
    logic [23:0] w;
    slot = m_cnt / 32; b = m_cnt % 32;
    t0 = is_i2s() ? 0 : 2 * int'(slot_cfg[1:0]);
    exp_oe = m_locked && slot < slots() && (slot == t0 || slot == t0 + 1);
    w = (slot == t0) ? m_f0 : m_f1;
    exp_sd = exp_oe && b < 24 && w[23-b];
  endtask

  // Per-clock comparison against the model (R5, R6, R7 on every clock).
  initial forever begin
    @(posedge bclk); #1;
    if (model_on) begin
      chk({tag, " oe"}, 32'(sdata_oe), 32'(exp_oe));
      chk({tag, " data"}, 32'(sdata), 32'(exp_sd));
      model_pos();
      chk({tag, " ready R8"}, 32'(in_ready), 32'(!m_hfull));
    end
    @(negedge bclk); #1;
    if (model_on) model_neg();
  end

  task automatic new_data();
    k++;
    in_ch0 = (k % 7 == 0) ? 24'h800000 : 24'h5A3C96 ^ 24'(k * 24'h013579);
    in_ch1 = (k % 7 == 3) ? 24'h7FFFFF : 24'hC3A501 ^ 24'(k * 24'h02468B);
  endtask

  task automatic drive(input logic fs);
    @(negedge bclk); #3;
    fsync = fs;
    if (in_valid && m_acc) begin
      if (feed_on) new_data(); else in_valid = 0;
    end else if (!in_valid && feed_on) begin
      in_valid = 1; new_data();
    end
  endtask

  task automatic i2s_frames(int n);
    repeat (n) begin repeat (32) drive(0); repeat (32) drive(1); end
  endtask

  task automatic tdm_frames(int n, int bits, int w);
    repeat (n) for (int i = 0; i < bits; i++) drive(i < w);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #1000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    rst_n = 0; fsync = 0; in_valid = 0; in_ch0 = 0; in_ch1 = 0;
    ratio_code = 3'd3; slot_cfg = 3'd0;
    #23;
    chk("R10 reset oe", 32'(sdata_oe), 0);
    chk("R10 reset data", 32'(sdata), 0);
    chk("R10 reset ready", 32'(in_ready), 1);
    @(negedge bclk); #3; rst_n = 1; model_on = 1;
    // R10: no sync edge yet, nothing driven; R8: back-pressure while idle
    tag = "R10"; feed_on = 1;
    repeat (80) drive(0);
    // R3 R5: each TDM slot pair with 8 slots
    tag = "R3 R5";
    for (int p = 0; p < 4; p++) begin slot_cfg = 3'(p); tdm_frames(3, 256, 1); end
    // R2: wide sync pulse, falling edge mid-frame ignored
    tag = "R2"; slot_cfg = 3'd2; tdm_frames(3, 256, 40);
    // R4: slot pairs past the frame end are dropped
    tag = "R4"; ratio_code = 3'd1; slot_cfg = 3'd2; tdm_frames(3, 128, 1);
    slot_cfg = 3'd3; tdm_frames(3, 128, 1);
    slot_cfg = 3'd1; tdm_frames(2, 128, 1);
    ratio_code = 3'd2; slot_cfg = 3'd3; tdm_frames(3, 192, 2);
    ratio_code = 3'd4; tdm_frames(2, 384, 1);
    ratio_code = 3'd5; tdm_frames(2, 512, 3);
    ratio_code = 3'd7; slot_cfg = 3'd0; tdm_frames(2, 512, 1);
    // R1: I2S forced by the config bit, then by the 64x ratio
    tag = "R1"; ratio_code = 3'd3; slot_cfg = 3'd4; i2s_frames(4);
    ratio_code = 3'd0; slot_cfg = 3'd1; i2s_frames(4);
    // R9 R8: producer stops, last pair repeats, then resumes
    tag = "R9 R8"; ratio_code = 3'd3; slot_cfg = 3'd1; feed_on = 0;
    tdm_frames(4, 256, 1);
    feed_on = 1; tdm_frames(3, 256, 1);
    repeat (4) drive(0);
    summary();
  end
endmodule